// File: doc/BRIEF.md
# Prioritized Nested Exception Controller

This block keeps track of a fixed set of exception and interrupt sources and decides which one a processor core should service next. Every source sits in one of three states: inactive (neither pending nor active), pending, or active, and a source that is active may also be pending again. Three sources have fixed urgency above every programmable level: source 1 is the most urgent, then source 2 (the non-maskable source), then source 3 (the fault source). All sources numbered 4 and up carry a programmable priority, and lower values are more urgent. Number 0 means "no exception" and never becomes pending.

A grouping field splits each priority into a group part and a subpriority part. Only the group part decides whether a pending source may interrupt the handler that is running. The full value (group, then subpriority, then the lower source number) orders pending sources against each other. Active handlers are held on a nesting stack. A core model raises an entry acknowledge when it takes the offered exception and a return strobe when the current handler finishes.

Software reaches enables, pending bits, priorities and the grouping field through a simple single-cycle register bus with combinational read data.

Top module: `exc_ctrl`

## Requirements
- R1: After reset no source is pending or active, every enable, priority and the grouping field read 0, `act_num` and `pend_num` are 0 and `irq_req` is low.
- R2: A high `src_req` bit for one cycle makes that source pending. Writing ones to address 0x01 sets pending bits and writing ones to address 0x02 clears them. Set wins over clear. Bit 0 is never set. Both addresses read back the pending vector, with bit k for source k.
- R3: A source numbered 4 or above is considered for selection only when its bit in the enable register (address 0x00, bit k) is 1. Sources 1 to 3 ignore enables. Enable bits 0 to 3 read 0. A disabled source stays pending.
- R4: The priority of source k sits at address 0x20+k as an 8-bit value of which only the top PRIO_BITS bits are stored. The lower bits read 0. Entries for sources 0 to 3 read 0 and ignore writes.
- R5: `pend_num` is the eligible pending source with the most urgent full priority, or 0 if there is none. Sources 1, 2 and 3 beat every programmable source and are ordered 1, 2, 3 among themselves. Among equal programmable values the lower number wins.
- R6: With grouping value g at address 0x04 (3 bits), the group part of a priority is bits [7:g+1], so g=7 leaves no group bits. `irq_req` is high only when a source is selected and either no handler is active or the selected source's group part is strictly more urgent than that of the active handler. Fixed sources count as more urgent than any group.
- R7: When `entry_ack` is high with `irq_req` high, at the next edge the source given by `pend_num` loses its pending state, becomes active and is pushed, so `act_num` shows it.
- R8: A `ret_valid` strobe pops the top handler and makes it inactive, or leaves it pending if it was requested again while active. `act_num` then shows the handler below it, or 0.
- R9: When `ret_valid` and `entry_ack` are high in the same cycle, only the return takes place. A `ret_valid` with no active handler has no effect.
- R10: Address 0x03 reads the active vector, with bit k for source k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | N_SRC | Hardware request pulses, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Selected source may be entered now |
| entry_ack | input | 1 | Core takes the offered exception |
| ret_valid | input | 1 | Core returns from the current handler |
| act_num | output | $clog2(N_SRC) | Number of the running handler, 0 if none |
| pend_num | output | $clog2(N_SRC) | Number of the most urgent eligible pending source, 0 if none |

## Verification
The bench builds the block with 12 sources and 3 stored priority bits. That gives eight levels, so the grouping values 4 to 7 cover every split: all three bits as group, two, one, and none. A written value with low bits set shows how those bits are dropped. With this build the bench drives three-deep nesting that is limited by group rather than subpriority, fixed sources preempting a handler with no group bits, and a return that collides with an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int PRIO_FIELD_W = 8;
   localparam int FIXED_LAST   = 3;
   localparam int FIRST_PROG   = 4;

   // ordering key: MSB 0 marks a fixed source, lower value is more urgent
   typedef logic [PRIO_FIELD_W:0] exc_key_t;

   function automatic logic [PRIO_FIELD_W-1:0] group_mask(input logic [2:0] grp);
      logic [PRIO_FIELD_W-1:0] m;
      for (int i = 0; i < PRIO_FIELD_W; i++) m[i] = (i > int'(grp));
      return m;
   endfunction

   function automatic exc_key_t rank_key(input logic                    fixed_src,
                                         input logic [1:0]              rank,
                                         input logic [PRIO_FIELD_W-1:0] prio,
                                         input logic [PRIO_FIELD_W-1:0] mask);
      return fixed_src ? {7'd0, rank} : {1'b1, prio & mask};
   endfunction

endpackage

// File: rtl/exc_prio_regs.sv
module exc_prio_regs #(
   parameter  int N_SRC     = 16,
   parameter  int PRIO_BITS = 4,
   localparam int NW        = $clog2(N_SRC)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [NW-1:0]         idx,
   input  logic [PRIO_BITS-1:0]  wdata,
   output logic [N_SRC-1:0][7:0] prio8
);

   for (genvar k = 0; k < N_SRC; k++) begin : g_src
      if (k >= exc_pkg::FIRST_PROG) begin : g_prog
         logic [PRIO_BITS-1:0] lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       lvl_q <= '0;
            else if (we && idx == NW'(k))     lvl_q <= wdata;
         end
         if (PRIO_BITS == 8) begin : g_full
            assign prio8[k] = lvl_q;
         end else begin : g_part
            assign prio8[k] = {lvl_q, {(8-PRIO_BITS){1'b0}}};
         end
      end else begin : g_fixed
         assign prio8[k] = '0;
      end
   end

endmodule

// File: rtl/exc_state_bank.sv
module exc_state_bank #(
   parameter  int N_SRC = 16,
   localparam int NW    = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_mask,
   input  logic [N_SRC-1:0] clr_mask,
   input  logic             take,
   input  logic [NW-1:0]    take_num,
   input  logic             drop,
   input  logic [NW-1:0]    drop_num,
   output logic [N_SRC-1:0] pend_o,
   output logic [N_SRC-1:0] act_o
);

   for (genvar k = 0; k < N_SRC; k++) begin : g_src
      logic pend_q, act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            act_q  <= 1'b0;
         end else begin
            if (set_mask[k])
               pend_q <= 1'b1;
            else if (clr_mask[k] || (take && take_num == NW'(k)))
               pend_q <= 1'b0;
            if (take && take_num == NW'(k))
               act_q <= 1'b1;
            else if (drop && drop_num == NW'(k))
               act_q <= 1'b0;
         end
      end
      assign pend_o[k] = pend_q;
      assign act_o[k]  = act_q;
   end

endmodule

// File: rtl/exc_arb.sv
module exc_arb #(
   parameter  int N_SRC = 16,
   localparam int NW    = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]      elig,
   input  logic [N_SRC-1:0][7:0] prio8,
   input  logic [2:0]            grp,
   input  logic                  top_valid,
   input  logic [NW-1:0]         top_num,
   output logic [NW-1:0]         hp_num,
   output logic                  preempt
);
   import exc_pkg::*;

   logic [7:0] gmask;
   exc_key_t   best_full, best_grp, top_grp, cand;
   logic       found, top_fixed, k_fixed;

   always_comb begin
      gmask     = group_mask(grp);
      best_full = '1;
      best_grp  = '1;
      found     = 1'b0;
      hp_num    = '0;
      for (int k = 0; k < N_SRC; k++) begin
         k_fixed = (k >= 1) && (k <= FIXED_LAST);
         cand    = rank_key(k_fixed, 2'(k - 1), prio8[k], 8'hFF);
         if (elig[k] && (!found || cand < best_full)) begin
            found     = 1'b1;
            best_full = cand;
            best_grp  = rank_key(k_fixed, 2'(k - 1), prio8[k], gmask);
            hp_num    = NW'(k);
         end
      end
      top_fixed = (top_num >= NW'(1)) && (top_num <= NW'(FIXED_LAST));
      top_grp   = rank_key(top_fixed, 2'(top_num - 1'b1), prio8[top_num], gmask);
      preempt   = found && (!top_valid || best_grp < top_grp);
   end

endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
   parameter  int N_SRC = 16,
   parameter  int DEPTH = 19,
   localparam int NW    = $clog2(N_SRC),
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [NW-1:0] push_num,
   input  logic          pop,
   output logic          top_valid,
   output logic [NW-1:0] top_num
);

   logic [NW-1:0] slot_q [DEPTH];
   logic [CW-1:0] cnt_q;
   logic          room;

   assign room = (cnt_q != CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (push && room) slot_q[AW'(cnt_q)] <= push_num;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (push && room)            cnt_q <= cnt_q + 1'b1;
      else if (pop && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign top_valid = (cnt_q != '0);
   assign top_num   = top_valid ? slot_q[AW'(cnt_q - 1'b1)] : '0;

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
   parameter  int N_SRC     = 16,
   parameter  int PRIO_BITS = 4,
   parameter  int ADDR_W    = 6,
   localparam int NW        = $clog2(N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_req,
   input  logic              entry_ack,
   input  logic              ret_valid,
   output logic [NW-1:0]     act_num,
   output logic [NW-1:0]     pend_num
);

   // every programmable group level plus the fixed sources can nest once
   localparam int DEPTH = (1 << PRIO_BITS) + exc_pkg::FIXED_LAST;

   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_GRP  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(32);

   localparam logic [N_SRC-1:0] FIXED_MASK = N_SRC'(14);
   localparam logic [N_SRC-1:0] PROG_MASK  = ~N_SRC'(15);

   if (N_SRC < 5 || N_SRC > 32) begin : g_bad_nsrc
      $error("exc_ctrl: N_SRC must lie in 5..32");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("exc_ctrl: PRIO_BITS must lie in 1..8");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("exc_ctrl: ADDR_W must be at least 6");
   end

   logic [N_SRC-1:0]      en_q, pend_v, act_v, set_mask, clr_mask, wsel;
   logic [2:0]            grp_q;
   logic [N_SRC-1:0][7:0] prio8;
   logic [ADDR_W-1:0]     prio_off;
   logic                  in_prio, take, drop, top_valid, preempt;
   logic [NW-1:0]         top_num, hp_num;
   logic                  unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wsel         = bus_wdata[N_SRC-1:0];
   assign prio_off     = bus_addr - A_PRIO;
   assign in_prio      = (bus_addr >= A_PRIO) && (prio_off < ADDR_W'(N_SRC));

   assign set_mask = (src_req | ((bus_we && bus_addr == A_SET) ? wsel : '0)) & ~N_SRC'(1);
   assign clr_mask = (bus_we && bus_addr == A_CLR) ? wsel : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         grp_q <= '0;
      end else if (bus_we) begin
         if (bus_addr == A_EN)  en_q  <= wsel & PROG_MASK;
         if (bus_addr == A_GRP) grp_q <= bus_wdata[2:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_EN:         bus_rdata[N_SRC-1:0] = en_q;
         A_SET, A_CLR: bus_rdata[N_SRC-1:0] = pend_v;
         A_ACT:        bus_rdata[N_SRC-1:0] = act_v;
         A_GRP:        bus_rdata[2:0]       = grp_q;
         default:      if (in_prio) bus_rdata[7:0] = prio8[prio_off[NW-1:0]];
      endcase
   end

   assign take = entry_ack && irq_req && !ret_valid;
   assign drop = ret_valid && top_valid;

   exc_prio_regs #(.N_SRC(N_SRC), .PRIO_BITS(PRIO_BITS)) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we && in_prio),
      .idx   (prio_off[NW-1:0]),
      .wdata (bus_wdata[7 -: PRIO_BITS]),
      .prio8 (prio8)
   );

   exc_state_bank #(.N_SRC(N_SRC)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .take     (take),
      .take_num (hp_num),
      .drop     (drop),
      .drop_num (top_num),
      .pend_o   (pend_v),
      .act_o    (act_v)
   );

   exc_arb #(.N_SRC(N_SRC)) u_arb (
      .elig      (pend_v & (en_q | FIXED_MASK)),
      .prio8     (prio8),
      .grp       (grp_q),
      .top_valid (top_valid),
      .top_num   (top_num),
      .hp_num    (hp_num),
      .preempt   (preempt)
   );

   exc_nest_stack #(.N_SRC(N_SRC), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (take),
      .push_num  (hp_num),
      .pop       (drop),
      .top_valid (top_valid),
      .top_num   (top_num)
   );

   assign irq_req  = preempt;
   assign act_num  = top_num;
   assign pend_num = hp_num;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
   parameter  int N_SRC = 16,
   localparam int NW    = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_req,
   input logic             entry_ack,
   input logic             ret_valid,
   input logic [NW-1:0]    act_num,
   input logic [NW-1:0]    pend_num,
   input logic [N_SRC-1:0] pend_vec,
   input logic [N_SRC-1:0] act_vec,
   input logic [N_SRC-1:0] en_vec
);

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (act_num == '0 && pend_num == '0 && !irq_req));

   p_sel_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_num != '0 |-> pend_vec[pend_num]);

   p_sel_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_num >= NW'(4) |-> en_vec[pend_num]);

   p_req_has_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> pend_num != '0);

   p_entry_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_ack && irq_req && !ret_valid) |=>
         (act_num == $past(pend_num) && act_vec[act_num]));

   p_return_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && act_num != '0) |=>
         (act_num != $past(act_num) && !act_vec[$past(act_num)]));

   p_idle_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !entry_ack && act_num == '0) |=> act_num == '0);

endmodule

bind exc_ctrl exc_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .entry_ack (entry_ack),
   .ret_valid (ret_valid),
   .act_num   (act_num),
   .pend_num  (pend_num),
   .pend_vec  (pend_v),
   .act_vec   (act_v),
   .en_vec    (en_q)
);

// File: tb/sim_exc_ctrl.sv
`timescale 1ns/1ps
module sim_exc_ctrl;

   localparam int N  = 12;
   localparam int P  = 3;
   localparam int NW = $clog2(N);

   typedef struct packed {
      logic [15:0] en;
      logic [15:0] pend;
      logic [3:0]  exp;
   } row_t;

   // enable mask, pending mask, expected pend_num (grouping 0, nothing active)
   localparam row_t ROWS [11] = '{
      '{16'h0FF0, 16'h0090, 4'd4},
      '{16'h0FF0, 16'h0060, 4'd5},
      '{16'h0FF0, 16'h0240, 4'd6},
      '{16'h0FF0, 16'h0114, 4'd2},
      '{16'h0FF0, 16'h000E, 4'd1},
      '{16'h0FF0, 16'h0408, 4'd3},
      '{16'h0010, 16'h0130, 4'd4},
      '{16'h0000, 16'h0084, 4'd2},
      '{16'h0000, 16'h0080, 4'd0},
      '{16'h0FF0, 16'h0C00, 4'd10},
      '{16'h0FF0, 16'h0180, 4'd8}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_req = '0;
   logic          bus_we = 1'b0;
   logic [5:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_req;
   logic          entry_ack = 1'b0;
   logic          ret_valid = 1'b0;
   logic [NW-1:0] act_num, pend_num;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   exc_ctrl #(.N_SRC(N), .PRIO_BITS(P)) u0 (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .entry_ack(entry_ack), .ret_valid(ret_valid),
      .act_num(act_num), .pend_num(pend_num)
   );

   task automatic chk(input string tag, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [5:0] a, output int d);
      @(negedge clk);
      bus_addr = a;
      #1 d = int'(bus_rdata);
   endtask

   task automatic core(input logic ack, input logic ret);
      @(negedge clk);
      entry_ack = ack; ret_valid = ret;
      @(negedge clk);
      entry_ack = 1'b0; ret_valid = 1'b0;
      #1;
   endtask

   task automatic pulse(input int k);
      @(negedge clk);
      src_req[k] = 1'b1;
      @(negedge clk);
      src_req[k] = 1'b0;
      #1;
   endtask

   initial begin
      #800000;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 act_num", int'(act_num), 0);
      chk("R1 pend_num", int'(pend_num), 0);
      chk("R1 irq_req", int'(irq_req), 0);
      rd(6'h00, v); chk("R1 enables", v, 0);
      rd(6'h24, v); chk("R1 priority", v, 0);
      rd(6'h04, v); chk("R1 grouping", v, 0);
      rd(6'h01, v); chk("R1 pending", v, 0);

      // R4: truncated priority, fixed entries not writable
      wr(6'h24, 32'h7F); rd(6'h24, v); chk("R4 low bits read zero", v, 'h60);
      wr(6'h22, 32'hFF); rd(6'h22, v); chk("R4 fixed entry", v, 0);
      wr(6'h00, 32'hF);  rd(6'h00, v); chk("R3 fixed enable bits", v, 0);
      wr(6'h25, 32'h40); wr(6'h26, 32'h40); wr(6'h27, 32'hA0);
      wr(6'h28, 32'h20); wr(6'h29, 32'hE0);

      // R2: set/clear paths and bit 0
      wr(6'h01, 32'h1); rd(6'h01, v); chk("R2 bit0 ignored", v, 0);
      pulse(9);         rd(6'h01, v); chk("R2 hw request", v, 'h200);
      wr(6'h02, 32'h200); rd(6'h02, v); chk("R2 clear", v, 0);

      // R5/R3: selection table
      for (int i = 0; i < 11; i++) begin
         wr(6'h02, 32'hFFF);
         wr(6'h00, 32'(ROWS[i].en));
         wr(6'h01, 32'(ROWS[i].pend));
         chk($sformatf("R5 row %0d pend_num", i), int'(pend_num), int'(ROWS[i].exp));
         chk($sformatf("R6 row %0d irq_req", i), int'(irq_req), int'(ROWS[i].exp != 0));
         rd(6'h01, v);
         chk($sformatf("R2 row %0d pending", i), v, int'(ROWS[i].pend) & 'hFFE);
      end

      // R6/R7/R8: group-limited nesting with grouping 5 (group = bits 7:6)
      wr(6'h02, 32'hFFF);
      wr(6'h00, 32'hFF0);
      wr(6'h04, 32'd5);
      wr(6'h01, 32'h080);
      chk("R6 idle offer", int'(irq_req), 1);
      core(1'b1, 1'b0);
      chk("R7 entry 7", int'(act_num), 7);
      chk("R7 pending cleared", int'(pend_num), 0);
      wr(6'h01, 32'h010);
      chk("R6 more urgent group", int'(irq_req), 1);
      core(1'b1, 1'b0);
      chk("R7 entry 4", int'(act_num), 4);
      wr(6'h01, 32'h020);
      chk("R5 sub-priority candidate", int'(pend_num), 5);
      chk("R6 same group no preempt", int'(irq_req), 0);
      wr(6'h01, 32'h100);
      chk("R6 group 0 candidate", int'(pend_num), 8);
      chk("R6 group 0 preempts", int'(irq_req), 1);
      core(1'b1, 1'b0);
      chk("R7 entry 8", int'(act_num), 8);
      chk("R6 after nest", int'(irq_req), 0);
      rd(6'h03, v); chk("R10 active vector", v, 'h190);
      core(1'b0, 1'b1);
      chk("R8 pop to 4", int'(act_num), 4);
      chk("R6 still blocked", int'(irq_req), 0);
      core(1'b0, 1'b1);
      chk("R8 pop to 7", int'(act_num), 7);
      chk("R6 unblocked", int'(irq_req), 1);
      wr(6'h04, 32'd7);
      chk("R6 no group bits", int'(irq_req), 0);

      // fixed sources and the entry/return collision
      wr(6'h01, 32'h004);
      chk("R5 fixed wins", int'(pend_num), 2);
      chk("R6 fixed preempts", int'(irq_req), 1);
      core(1'b1, 1'b0);
      chk("R7 entry 2", int'(act_num), 2);
      wr(6'h01, 32'h002);
      chk("R6 source 1 over 2", int'(irq_req), 1);
      core(1'b1, 1'b1);
      chk("R9 collision pops only", int'(act_num), 7);
      rd(6'h01, v); chk("R9 source 1 still pending", v, 'h022);
      core(1'b1, 1'b0);
      chk("R7 entry 1", int'(act_num), 1);
      core(1'b0, 1'b1);
      core(1'b0, 1'b1);
      chk("R8 stack empty", int'(act_num), 0);
      core(1'b0, 1'b1);
      chk("R9 empty return", int'(act_num), 0);
      chk("R9 offer kept", int'(pend_num), 5);

      // R8: re-request while active
      wr(6'h02, 32'hFFF);
      wr(6'h01, 32'h200);
      core(1'b1, 1'b0);
      chk("R7 entry 9", int'(act_num), 9);
      pulse(9);
      chk("R8 re-request pending", int'(pend_num), 9);
      chk("R8 no self preempt", int'(irq_req), 0);
      core(1'b0, 1'b1);
      chk("R8 return to idle", int'(act_num), 0);
      rd(6'h01, v); chk("R8 back to pending", v, 'h200);
      chk("R8 offered again", int'(irq_req), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule